// File: doc/BRIEF.md
# Latch-Based Multiphase Clock Generator

This block produces a set of non-overlapping phase enables from a twisted-ring counter. The ring holds one level-sensitive latch per stage instead of one flip-flop. Even-indexed stages are open while the clock is high and odd-indexed stages are open while it is low. Each stage therefore takes its new value while its neighbour is closed, and data never passes through two open stages in one half period. A ring of `RING_LEN` latches steps once per half period, so it passes through `2*RING_LEN` states in `RING_LEN` clock cycles. Each state is decoded from one adjacent pair of ring bits into one phase line.

A synchronous reset clears the ring. A load port can place any pattern into the ring, so the ring can be started at a chosen state, or a corrupted one can be modelled. Logic beside the ring checks the ring at every rising edge. When it finds a pattern that is not a twisted-ring state, it clears the ring for one clock cycle and the rotation then restarts. The block has no streaming interface. It has only a clock, control pins and plain status outputs, so no back-pressure applies.

Top module: `mpc_gen`

## Requirements
- R1: A rising edge that samples `rst_i` high clears the ring: `ring_o` is all zeros from the next falling edge, and `phase_o` then shows only bit `2*RING_LEN-1`, for as long as reset stays sampled high.
- R2: After a reset, the first rising edge that samples `rst_i` low restarts the ring. In the high half that follows, `ring_o` equals 1 (only bit 0 set) and `phase_o` bit 0 is set.
- R3: Ring bits with an even index change only while `clk_i` is high. Ring bits with an odd index change only while `clk_i` is low. Each bit holds its value through the other half.
- R4: With no clear and no load active, the ring moves to the next twisted-ring state every half period. Ones fill in from bit 0 upward until all bits are one, then zeros fill in from bit 0 upward until all bits are zero. One rotation takes `RING_LEN` clock cycles.
- R5: `phase_o` is a one-hot decode of the ring. For index p < `RING_LEN`, the ring is ones in bits 0..p and zeros above. For p >= `RING_LEN`, the ring is zeros in bits 0..p-`RING_LEN` and ones above. The all-zero ring is p = `2*RING_LEN-1`.
- R6: While the ring runs freely, even phase indices are asserted only in the high half of the clock and odd indices only in the low half.
- R7: A rising edge that samples `ld_en_i` high with `rst_i` low starts a load. During the next clock period, even bits take their `ld_val_i` value in the high half and odd bits take theirs in the low half. The ring equals `ld_val_i` by the end of that period.
- R8: If the ring holds a pattern with more than one position where bits i and i+1 differ at a rising edge, the ring is all zeros by the next rising edge. Phase 0 follows in the high half after that edge, so recovery finishes within two clock cycles, well inside one rotation.
- R9: A loaded pattern that is a legal twisted-ring state is not cleared, and the rotation continues from it.
- R10: Reset takes priority over load: with both sampled high, the ring clears and the load value is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; its level selects which stages are open |
| rst_i | input | 1 | Synchronous reset, sampled on the rising edge |
| ld_en_i | input | 1 | Load request, sampled on the rising edge |
| ld_val_i | input | RING_LEN | Pattern to place into the ring |
| ring_o | output | RING_LEN | Current ring contents, bit i from stage i |
| phase_o | output | 2*RING_LEN | One-hot phase lines |

## Verification
Reset, load and clear decisions are registered on the rising edge. Their effect shows in the even stages during the high half after that edge, and in the odd stages during the following low half. The bench model applies each decision at the same edge and splits its effect into the same two halves. The ring moves once per half period, so outputs are compared one nanosecond after every rising and every falling edge. That point lies inside the half the result belongs to and clear of the edge itself. A load appears in full by the end of the clock period after the request, an illegal pattern reads zero one period later, and phase 0 comes in the high half after that; the directed checks sample at exactly those halves.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  typedef enum logic {
    OPEN_LOW  = 1'b0,
    OPEN_HIGH = 1'b1
  } open_lvl_e;

  function automatic open_lvl_e stage_level(input int unsigned idx);
    return (idx % 2 == 0) ? OPEN_HIGH : OPEN_LOW;
  endfunction
endpackage

// File: rtl/mpc_stage_latch.sv
module mpc_stage_latch #(
  parameter mpc_pkg::open_lvl_e OPEN_ON = mpc_pkg::OPEN_HIGH
) (
  input  logic clk_i,
  input  logic clr_i,
  input  logic ld_i,
  input  logic ld_bit_i,
  input  logic shift_i,
  output logic q_o
);
  logic open_w;

  generate
    if (OPEN_ON == mpc_pkg::OPEN_HIGH) begin : g_hi
      assign open_w = clk_i;
    end else begin : g_lo
      assign open_w = ~clk_i;
    end
  endgenerate

  // Transparent only on its own clock level; clear beats load beats shift.
  always_latch begin
    if (open_w) begin
      if (clr_i)     q_o <= 1'b0;
      else if (ld_i) q_o <= ld_bit_i;
      else           q_o <= shift_i;
    end
  end
endmodule

// File: rtl/mpc_latch_ring.sv
module mpc_latch_ring #(
  parameter int unsigned RING_LEN = 6
) (
  input  logic                clk_i,
  input  logic                clr_i,
  input  logic                ld_i,
  input  logic [RING_LEN-1:0] ld_val_i,
  output logic [RING_LEN-1:0] ring_o
);
  logic [RING_LEN-1:0] feed_w;

  // Twisted feedback: stage 0 takes the inverse of the last stage.
  assign feed_w[0] = ~ring_o[RING_LEN-1];

  generate
    for (genvar s = 1; s < RING_LEN; s++) begin : g_feed
      assign feed_w[s] = ring_o[s-1];
    end

    for (genvar s = 0; s < RING_LEN; s++) begin : g_stage
      mpc_stage_latch #(
        .OPEN_ON(mpc_pkg::stage_level(s))
      ) stage_i (
        .clk_i   (clk_i),
        .clr_i   (clr_i),
        .ld_i    (ld_i),
        .ld_bit_i(ld_val_i[s]),
        .shift_i (feed_w[s]),
        .q_o     (ring_o[s])
      );
    end
  endgenerate
endmodule

// File: rtl/mpc_ring_guard.sv
module mpc_ring_guard #(
  parameter int unsigned RING_LEN = 6
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                ld_en_i,
  input  logic [RING_LEN-1:0] ld_val_i,
  input  logic [RING_LEN-1:0] ring_i,
  output logic                clr_o,
  output logic                ld_o,
  output logic [RING_LEN-1:0] ld_val_o
);
  localparam int unsigned HALF = RING_LEN / 2;

  logic [HALF-1:0]     even_snap_q;
  logic [RING_LEN-1:0] snap_w;
  logic [RING_LEN-2:0] step_w;
  logic                legal_w;

  // Even stages close at the falling edge; capture them there so that the
  // rising-edge check never races the stages that open on that edge.
  always_ff @(negedge clk_i) begin
    for (int j = 0; j < HALF; j++) begin
      even_snap_q[j] <= ring_i[2*j];
    end
  end

  generate
    for (genvar j = 0; j < HALF; j++) begin : g_snap
      assign snap_w[2*j]   = even_snap_q[j];
      assign snap_w[2*j+1] = ring_i[2*j+1];
    end
    for (genvar b = 0; b < RING_LEN - 1; b++) begin : g_step
      assign step_w[b] = snap_w[b] ^ snap_w[b+1];
    end
  endgenerate

  // A twisted-ring state has at most one boundary between ones and zeros.
  assign legal_w = $onehot0(step_w);

  always_ff @(posedge clk_i) begin
    clr_o    <= rst_i | ~legal_w;
    ld_o     <= ld_en_i & ~rst_i;
    ld_val_o <= ld_val_i;
  end
endmodule

// File: rtl/mpc_phase_decode.sv
module mpc_phase_decode #(
  parameter int unsigned RING_LEN = 6
) (
  input  logic [RING_LEN-1:0]   ring_i,
  output logic [2*RING_LEN-1:0] phase_o
);
  generate
    for (genvar p = 0; p < 2 * RING_LEN; p++) begin : g_ph
      if (p < RING_LEN - 1) begin : g_fill
        assign phase_o[p] = ring_i[p] & ~ring_i[p+1];
      end else if (p == RING_LEN - 1) begin : g_full
        assign phase_o[p] = ring_i[RING_LEN-1] & ring_i[0];
      end else if (p < 2 * RING_LEN - 1) begin : g_drain
        assign phase_o[p] = ~ring_i[p-RING_LEN] & ring_i[p-RING_LEN+1];
      end else begin : g_empty
        assign phase_o[p] = ~ring_i[RING_LEN-1] & ~ring_i[0];
      end
    end
  endgenerate
endmodule

// File: rtl/mpc_gen.sv
module mpc_gen #(
  parameter int unsigned RING_LEN = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  ld_en_i,
  input  logic [RING_LEN-1:0]   ld_val_i,
  output logic [RING_LEN-1:0]   ring_o,
  output logic [2*RING_LEN-1:0] phase_o
);
  logic                clr_q;
  logic                ld_q;
  logic [RING_LEN-1:0] ld_val_q;

  mpc_ring_guard #(.RING_LEN(RING_LEN)) guard_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .ld_en_i (ld_en_i),
    .ld_val_i(ld_val_i),
    .ring_i  (ring_o),
    .clr_o   (clr_q),
    .ld_o    (ld_q),
    .ld_val_o(ld_val_q)
  );

  mpc_latch_ring #(.RING_LEN(RING_LEN)) ring_i (
    .clk_i   (clk_i),
    .clr_i   (clr_q),
    .ld_i    (ld_q),
    .ld_val_i(ld_val_q),
    .ring_o  (ring_o)
  );

  mpc_phase_decode #(.RING_LEN(RING_LEN)) dec_i (
    .ring_i (ring_o),
    .phase_o(phase_o)
  );
endmodule

// File: rtl/mpc_gen_chk.sv
module mpc_gen_chk #(
  parameter int unsigned RING_LEN = 6
) (
  input logic                  clk_i,
  input logic                  rst_i,
  input logic [RING_LEN-1:0]   ld_val_i,
  input logic [RING_LEN-1:0]   ring_o,
  input logic [2*RING_LEN-1:0] phase_o,
  input logic                  clr_q,
  input logic                  ld_q
);
  localparam int unsigned NPH = 2 * RING_LEN;

  function automatic logic is_state(input logic [RING_LEN-1:0] v);
    logic [RING_LEN-1:0] ref_v;
    logic                hit;
    hit = 1'b0;
    for (int p = 0; p < NPH; p++) begin
      for (int b = 0; b < RING_LEN; b++) begin
        ref_v[b] = (p < RING_LEN) ? (b <= p) : (b > p - RING_LEN);
      end
      if (ref_v == v) hit = 1'b1;
    end
    return hit;
  endfunction

  function automatic logic [NPH-1:0] rot2(input logic [NPH-1:0] v);
    return {v[NPH-3:0], v[NPH-1:NPH-2]};
  endfunction

  logic [1:0] quiet_q;
  always_ff @(posedge clk_i) begin
    if (rst_i || clr_q || ld_q) quiet_q <= 2'd0;
    else if (quiet_q != 2'd3)   quiet_q <= quiet_q + 2'd1;
  end

  AST_PHASE_ONEHOT_HI: assert property (@(negedge clk_i) disable iff (rst_i || clr_q || ld_q)
    $onehot(phase_o)); // R5
  AST_PHASE_ONEHOT_LO: assert property (@(posedge clk_i) disable iff (rst_i || clr_q || ld_q)
    $onehot(phase_o)); // R5
  AST_ROTATE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (quiet_q >= 2'd2 && !clr_q && !ld_q) |-> phase_o == rot2($past(phase_o))); // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_q |-> ring_o == '0); // R8
  AST_ILLEGAL_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
    !is_state(ring_o) |=> clr_q); // R8
  AST_LOAD_LANDS: assert property (@(posedge clk_i) disable iff (rst_i)
    (ld_q && !clr_q) |-> ring_o == $past(ld_val_i)); // R7
endmodule

bind mpc_gen mpc_gen_chk #(.RING_LEN(RING_LEN)) chk_i (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .ld_val_i(ld_val_i),
  .ring_o  (ring_o),
  .phase_o (phase_o),
  .clr_q   (clr_q),
  .ld_q    (ld_q)
);

// File: tb/mpc_gen_tb_top.sv
`timescale 1ns/100ps
module mpc_gen_tb_top;
  localparam int L  = 6;
  localparam int NP = 2 * L;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_en = 1'b0;
  logic [L-1:0]  ld_val = '0;
  logic [L-1:0]  ring;
  logic [NP-1:0] phase;

  always #2 clk = ~clk;

  mpc_gen #(.RING_LEN(L)) dut_i (
    .clk_i   (clk),
    .rst_i   (rst),
    .ld_en_i (ld_en),
    .ld_val_i(ld_val),
    .ring_o  (ring),
    .phase_o (phase)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [L-1:0] mr = '0;
  logic [L-1:0] prev_ring = '0;
  logic [L-1:0] m_val = '0;
  bit m_clr = 0, m_ld = 0, have_prev = 0;
  int skip_n = 2;

  function automatic logic [L-1:0] pat(input int p);
    logic [L-1:0] r;
    for (int b = 0; b < L; b++) r[b] = (p < L) ? (b <= p) : (b > p - L);
    return r;
  endfunction

  function automatic int idx(input logic [L-1:0] v);
    for (int p = 0; p < NP; p++) if (pat(p) === v) return p;
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic half(input bit hi);
    logic [L-1:0] mask;
    bit adv;
    int p;
    adv = 0;
    for (int b = 0; b < L; b++) mask[b] = ((b % 2 == 0) == hi);
    if (hi) begin
      m_clr = rst || (idx(mr) < 0);
      m_ld  = ld_en && !rst;
      m_val = ld_val;
    end
    if (m_clr)     mr = mr & ~mask;
    else if (m_ld) mr = (mr & ~mask) | (m_val & mask);
    else begin
      p = (idx(mr) + 1) % NP;
      if ((p % 2 == 0) == hi) begin
        mr = pat(p);
        adv = 1;
      end
    end
    #1;
    if (skip_n > 0) skip_n--;
    else begin
      chk(m_clr ? "R1" : (m_ld ? "R7" : "R4"), 64'(ring), 64'(mr));
      if (idx(mr) >= 0) chk("R5", 64'(phase), 64'(1) << idx(mr));
      if (have_prev) chk("R3", 64'(ring & ~mask), 64'(prev_ring & ~mask));
      if (adv) chk("R6", 64'(idx(ring) % 2), hi ? 64'd0 : 64'd1);
      have_prev = 1;
    end
    prev_ring = ring;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); half(1);
      @(negedge clk); half(0);
    end
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      summary();
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk("R1", 64'(ring), 64'd0);
    chk("R1", 64'(phase), 64'(1) << (NP - 1));
    rst = 1'b0;
    @(posedge clk); half(1);
    chk("R2", 64'(ring), 64'd1);
    chk("R2", 64'(phase), 64'd1);
    @(negedge clk); half(0);
    cyc(3 * L);

    // Illegal isolated one: cleared, then restart.
    ld_en = 1'b1; ld_val = 6'b000100;
    cyc(1);
    ld_en = 1'b0;
    chk("R7", 64'(ring), 64'(6'b000100));
    cyc(1);
    chk("R8", 64'(ring), 64'd0);
    cyc(1);
    chk("R8", 64'(ring), 64'(pat(1)));
    cyc(2 * L);

    // Legal odd-index state continues without clearing.
    ld_en = 1'b1; ld_val = pat(7);
    cyc(1);
    ld_en = 1'b0;
    cyc(3);
    chk("R9", 64'(ring), 64'(pat(1)));
    cyc(L);

    // Legal even-index state.
    ld_en = 1'b1; ld_val = pat(2);
    cyc(1);
    ld_en = 1'b0;
    cyc(2 * L);

    // Reset wins over load.
    rst = 1'b1; ld_en = 1'b1; ld_val = 6'b111111;
    cyc(1);
    chk("R10", 64'(ring), 64'd0);
    ld_en = 1'b0;
    cyc(1);
    rst = 1'b0;
    cyc(L);

    // Alternating pattern: many boundaries.
    ld_en = 1'b1; ld_val = 6'b101010;
    cyc(1);
    ld_en = 1'b0;
    cyc(1);
    chk("R8", 64'(ring), 64'd0);
    cyc(2 * L);

    done = 1;
    summary();
    $finish;
  end
endmodule